// File: doc/BRIEF.md
# Clock Configuration Write Lock

This unit guards the clock-control registers of a small controller. It sits on a simple write port (address, data, strobe) and holds the registers that choose and configure the CPU clock. Software can freeze the bits that decide whether the CPU keeps its clock. A runaway program then cannot stop the main oscillator, move the CPU off it, or disturb the PLL.

There are two levels of protection. A guard register holds a gate bit, and the power-mode register can only be changed while that gate is open. Bit 0 of the power-mode register is the clock lock. Once the lock is set, it masks a scattered, bit-granular set of clock-control bits until the next system reset. The lock is only accepted while the main clock is running and selected. An attempt under any other condition is refused and flagged. The intended use is: open the gate, set the lock, close the gate.

A small state machine tracks the gate and the lock. It has four states:
- FREE: gate closed, unlocked.
- ARMED: gate open, unlocked.
- LOCK_ARMED: gate open, locked.
- LOCKED: gate closed, locked.

Its transitions are:
- FREE→ARMED on writing gate=1.
- ARMED→FREE on writing gate=0.
- ARMED→LOCK_ARMED on an accepted lock request.
- LOCK_ARMED→LOCKED on writing gate=0.
- LOCKED→LOCK_ARMED on writing gate=1.

A refused request leaves the state in ARMED.

Top module: `clk_cfg_lock`

## Requirements
- R1: After reset the register values are: guard 0x00, power-mode 0x00, clk0 0x08, clk1 0x20, clk2 0x00, pll 0x12. Both lock_o and wait_block_o are 0.
- R2: The address map is: 0 guard, 1 power-mode, 2 clk0, 3 clk1, 4 clk2, 5 pll. While unlocked, a write to addresses 2–5 stores the full data byte. Writes to addresses 6 and 7 change nothing.
- R3: Guard bit 0 is the gate and can always be written; guard bits 7:1 read as 0. A power-mode write has no effect while the gate is 0.
- R4: The lock is granted when all of these hold: the gate is 1, a power-mode write has data bit 0 = 1, clk0 bit 0 (main clock stopped) is 0, and clk0 bit 1 (clock source select) is 0. lock_o is 1 from the cycle after that write.
- R5: A lock request is refused when the gate is 1 and clk0 bits 1:0 are not both 0. lock_o then stays 0, and lock_rej_o is high for exactly the one cycle after the write.
- R6: Once set, the lock is cleared only by reset. Writing power-mode bit 0 = 0 leaves it at 1, even with the gate open. Power-mode bits 7:1 remain writable while the gate is 1.
- R7: While locked, clk0 bits 2:0 keep their values on any write. Bits 7:3 stay writable.
- R8: While locked, clk1 bits 1:0 and clk2 bit 0 keep their values on any write. All other bits of those registers stay writable.
- R9: While locked, every bit of the pll register keeps its value.
- R10: viol_o is high for one cycle after a write that tried to change a locked bit. No pulse occurs when the written protected bits equal the stored ones, or when unlocked.
- R11: wait_block_o is 1 exactly when the lock is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| guard_q | output | 8 | Guard register (bit 0 = gate) |
| pmode_q | output | 8 | Power-mode register (bit 0 = lock) |
| clk0_q | output | 8 | Clock control 0 (bit 0 stop, bit 1 select) |
| clk1_q | output | 8 | Clock control 1 |
| clk2_q | output | 8 | Clock control 2 (bit 0 stop-detect enable) |
| pll_q | output | 8 | PLL control |
| lock_o | output | 1 | Clock lock active |
| wait_block_o | output | 1 | Wait-mode entry forbidden |
| viol_o | output | 1 | One-cycle protection-violation pulse |
| lock_rej_o | output | 1 | One-cycle refused-lock pulse |

## Verification
The hardest situation to reach from the ports is a locked unit under heavy traffic. Getting there takes an ordered three-write sequence, and the clock select and stop bits must be clear at the moment of the request. Random writes almost never line this up. The bench therefore drives the arming sequence directly: it first forces a refusal, then clears the clock bits and takes the lock. It then sends a long seeded random burst of writes to every address, biased toward protected registers. A bench model predicts every register value and pulse on each cycle.

// File: rtl/clk_lock_pkg.sv
package clk_lock_pkg;
    typedef enum logic [1:0] {
        ST_FREE       = 2'd0,
        ST_ARMED      = 2'd1,
        ST_LOCK_ARMED = 2'd2,
        ST_LOCKED     = 2'd3
    } lock_state_t;

    localparam int ADR_GUARD = 0;
    localparam int ADR_PMODE = 1;
    localparam int ADR_CLK_BASE = 2;
    localparam int NUM_CLK_REGS = 4;
endpackage

// File: rtl/clk_lock_fsm.sv
module clk_lock_fsm
    import clk_lock_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3,
    parameter int STOP_BIT = 0,
    parameter int SEL_BIT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] clk0_cur,
    output logic [DW-1:0] guard_q,
    output logic [DW-1:0] pmode_q,
    output logic          lock_o,
    output logic          wait_block_o,
    output logic          lock_rej_o
);
    lock_state_t state_q, state_d;
    logic [DW-2:0] pm_hi_q;
    logic          rej_q;
    logic          hit_guard, hit_pmode, clk_ok, req_lock, gate_open, locked;

    assign hit_guard = wr_en && (wr_addr == AW'(ADR_GUARD));
    assign hit_pmode = wr_en && (wr_addr == AW'(ADR_PMODE));
    assign clk_ok    = !clk0_cur[STOP_BIT] && !clk0_cur[SEL_BIT];
    assign req_lock  = hit_pmode && wr_data[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE:       if (hit_guard && wr_data[0]) state_d = ST_ARMED;
            ST_ARMED: begin
                if (hit_guard && !wr_data[0])   state_d = ST_FREE;
                else if (req_lock && clk_ok)    state_d = ST_LOCK_ARMED;
            end
            ST_LOCK_ARMED: if (hit_guard && !wr_data[0]) state_d = ST_LOCKED;
            ST_LOCKED:     if (hit_guard && wr_data[0])  state_d = ST_LOCK_ARMED;
            default:       state_d = ST_FREE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        gate_open = 1'b0;
        locked    = 1'b0;
        unique case (state_q)
            ST_FREE:       ;
            ST_ARMED:      gate_open = 1'b1;
            ST_LOCK_ARMED: begin gate_open = 1'b1; locked = 1'b1; end
            ST_LOCKED:     locked = 1'b1;
            default:       ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm_hi_q <= '0;
            rej_q   <= 1'b0;
        end else begin
            if (hit_pmode && gate_open) pm_hi_q <= wr_data[DW-1:1];
            rej_q <= (state_q == ST_ARMED) && req_lock && !clk_ok;
        end
    end

    assign guard_q      = {{(DW-1){1'b0}}, gate_open};
    assign pmode_q      = {pm_hi_q, locked};
    assign lock_o       = locked;
    assign wait_block_o = (state_q == ST_LOCKED) || (state_q == ST_LOCK_ARMED);
    assign lock_rej_o   = rej_q;
endmodule

// File: rtl/clk_lock_regs.sv
module clk_lock_regs
    import clk_lock_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3,
    parameter int NREG = NUM_CLK_REGS,
    parameter logic [NREG*DW-1:0] RST_VALS = '0,
    parameter logic [NREG*DW-1:0] GUARDS = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             lock,
    output logic [NREG*DW-1:0] regs_flat,
    output logic             viol_o
);
    logic [NREG-1:0] tried;
    logic            viol_q;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DW-1:0] RV = RST_VALS[g*DW +: DW];
        localparam logic [DW-1:0] GM = GUARDS[g*DW +: DW];
        logic [DW-1:0] cur_q, keep;
        logic          sel;

        assign sel  = wr_en && (wr_addr == AW'(ADR_CLK_BASE + g));
        assign keep = lock ? GM : '0;
        assign tried[g] = sel && |((wr_data ^ cur_q) & keep);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cur_q <= RV;
            else if (sel) cur_q <= (cur_q & keep) | (wr_data & ~keep);
        end
        assign regs_flat[g*DW +: DW] = cur_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) viol_q <= 1'b0;
        else        viol_q <= |tried;
    end
    assign viol_o = viol_q;
endmodule

// File: rtl/clk_cfg_lock.sv
module clk_cfg_lock
    import clk_lock_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3,
    parameter logic [7:0] CLK0_RST = 8'h08,
    parameter logic [7:0] CLK1_RST = 8'h20,
    parameter logic [7:0] CLK2_RST = 8'h00,
    parameter logic [7:0] PLL_RST  = 8'h12,
    parameter logic [7:0] CLK0_GUARD = 8'h07,
    parameter logic [7:0] CLK1_GUARD = 8'h03,
    parameter logic [7:0] CLK2_GUARD = 8'h01,
    parameter logic [7:0] PLL_GUARD  = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] guard_q,
    output logic [DW-1:0] pmode_q,
    output logic [DW-1:0] clk0_q,
    output logic [DW-1:0] clk1_q,
    output logic [DW-1:0] clk2_q,
    output logic [DW-1:0] pll_q,
    output logic          lock_o,
    output logic          wait_block_o,
    output logic          viol_o,
    output logic          lock_rej_o
);
    localparam int NREG = NUM_CLK_REGS;
    localparam logic [NREG*DW-1:0] RST_ALL =
        {DW'(PLL_RST), DW'(CLK2_RST), DW'(CLK1_RST), DW'(CLK0_RST)};
    localparam logic [NREG*DW-1:0] GUARD_ALL =
        {DW'(PLL_GUARD), DW'(CLK2_GUARD), DW'(CLK1_GUARD), DW'(CLK0_GUARD)};

    logic [NREG*DW-1:0] regs_flat;
    logic               lock_w;

    clk_lock_fsm #(.DW(DW), .AW(AW), .STOP_BIT(0), .SEL_BIT(1)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clk0_cur(regs_flat[DW-1:0]),
        .guard_q(guard_q), .pmode_q(pmode_q), .lock_o(lock_w),
        .wait_block_o(wait_block_o), .lock_rej_o(lock_rej_o)
    );

    clk_lock_regs #(.DW(DW), .AW(AW), .NREG(NREG),
                    .RST_VALS(RST_ALL), .GUARDS(GUARD_ALL)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .lock(lock_w), .regs_flat(regs_flat),
        .viol_o(viol_o)
    );

    assign lock_o = lock_w;
    assign clk0_q = regs_flat[0*DW +: DW];
    assign clk1_q = regs_flat[1*DW +: DW];
    assign clk2_q = regs_flat[2*DW +: DW];
    assign pll_q  = regs_flat[3*DW +: DW];
endmodule

// File: rtl/clk_cfg_lock_chk.sv
module clk_cfg_lock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] guard_q,
    input logic [7:0] pmode_q,
    input logic [7:0] clk0_q,
    input logic [7:0] clk1_q,
    input logic [7:0] clk2_q,
    input logic [7:0] pll_q,
    input logic       lock_o,
    input logic       wait_block_o,
    input logic       viol_o,
    input logic       lock_rej_o
);
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o); // R6
    AST_LOCK_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(guard_q[0])); // R4
    AST_LOCK_CLOCK_OK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> ($past(clk0_q[1:0]) == 2'b00)); // R4
    AST_CLK0_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_o) |-> (clk0_q[2:0] == $past(clk0_q[2:0]))); // R7
    AST_CLK12_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_o) |-> (clk1_q[1:0] == $past(clk1_q[1:0]) && clk2_q[0] == $past(clk2_q[0]))); // R8
    AST_PLL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_o) |-> $stable(pll_q)); // R9
    AST_VIOL_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> $past(lock_o)); // R10
    AST_REJ_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lock_rej_o |-> !lock_o); // R5
    AST_WAIT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        wait_block_o == pmode_q[0]); // R11
endmodule

bind clk_cfg_lock clk_cfg_lock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .guard_q(guard_q), .pmode_q(pmode_q),
    .clk0_q(clk0_q), .clk1_q(clk1_q), .clk2_q(clk2_q), .pll_q(pll_q),
    .lock_o(lock_o), .wait_block_o(wait_block_o), .viol_o(viol_o),
    .lock_rej_o(lock_rej_o)
);

// File: tb/clk_cfg_lock_bench.sv
module clk_cfg_lock_bench;
    localparam int CLK_P = 10;
    localparam int SEED = 1234;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] guard_q, pmode_q, clk0_q, clk1_q, clk2_q, pll_q;
    logic       lock_o, wait_block_o, viol_o, lock_rej_o;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    logic       m_gate, m_lock, m_viol, m_rej;
    logic [6:0] m_pmhi;
    logic [7:0] m_ck [4];

    always #(CLK_P/2) clk = ~clk;

    clk_cfg_lock u_clk_cfg_lock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .guard_q(guard_q), .pmode_q(pmode_q),
        .clk0_q(clk0_q), .clk1_q(clk1_q), .clk2_q(clk2_q), .pll_q(pll_q),
        .lock_o(lock_o), .wait_block_o(wait_block_o), .viol_o(viol_o),
        .lock_rej_o(lock_rej_o)
    );

    function automatic logic [7:0] guard_of(int idx);
        case (idx)
            0: return 8'h07;
            1: return 8'h03;
            2: return 8'h01;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic model_reset();
        m_gate = 0; m_lock = 0; m_viol = 0; m_rej = 0; m_pmhi = '0;
        m_ck[0] = 8'h08; m_ck[1] = 8'h20; m_ck[2] = 8'h00; m_ck[3] = 8'h12;
    endtask

    task automatic model_write(logic en, logic [2:0] a, logic [7:0] d);
        logic [7:0] keep;
        m_viol = 0; m_rej = 0;
        if (en) begin
            if (a == 3'd0) m_gate = d[0];
            else if (a == 3'd1) begin
                if (m_gate) begin
                    m_pmhi = d[7:1];
                    if (d[0] && !m_lock) begin
                        if (m_ck[0][1:0] == 2'b00) m_lock = 1;
                        else m_rej = 1;
                    end
                end
            end else if (a >= 3'd2 && a <= 3'd5) begin
                keep = m_lock ? guard_of(int'(a) - 2) : 8'h00;
                if (((d ^ m_ck[a-2]) & keep) != 0) m_viol = 1;
                m_ck[a-2] = (m_ck[a-2] & keep) | (d & ~keep);
            end
            // addresses 6 and 7: no effect (R2)
        end
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        check("R3 guard", guard_q, {7'b0, m_gate});
        check("R6 pmode", pmode_q, {m_pmhi, m_lock});
        check("R7 clk0", clk0_q, m_ck[0]);
        check("R8 clk1", clk1_q, m_ck[1]);
        check("R8 clk2", clk2_q, m_ck[2]);
        check("R9 pll", pll_q, m_ck[3]);
        check("R4 lock", {7'b0, lock_o}, {7'b0, m_lock});
        check("R11 wait_block", {7'b0, wait_block_o}, {7'b0, m_lock});
        check("R10 viol", {7'b0, viol_o}, {7'b0, m_viol});
        check("R5 lock_rej", {7'b0, lock_rej_o}, {7'b0, m_rej});
    endtask

    // one bus cycle: drive at negedge, check after the capturing edge
    task automatic bus(logic en, logic [2:0] a, logic [7:0] d);
        wr_en = en; wr_addr = a; wr_data = d;
        model_write(en, a, d);
        @(negedge clk);
        wr_en = 0;
        check_all();
    endtask

    task automatic do_reset();
        rst_n = 0; wr_en = 0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        check("R1 reset clk0", clk0_q, 8'h08);
        check("R1 reset clk1", clk1_q, 8'h20);
        check("R1 reset clk2", clk2_q, 8'h00);
        check("R1 reset pll", pll_q, 8'h12);
        check("R1 reset guard/pmode", guard_q | pmode_q, 8'h00);
        check("R1 reset lock/wait", {6'b0, lock_o, wait_block_o}, 8'h00);
    endtask

    task automatic random_burst(int n);
        for (int i = 0; i < n; i++) begin
            logic [2:0] a;
            logic [7:0] d;
            a = 3'($urandom_range(0, 7));
            d = 8'($urandom());
            if ($urandom_range(0, 3) == 0) d = '0;
            bus($urandom_range(0, 5) != 0, a, d);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(SEED));
        @(negedge clk);
        do_reset();

        // R2: full-byte writes while unlocked, ignored addresses
        bus(1, 3'd5, 8'hA5);
        bus(1, 3'd6, 8'hFF);
        bus(1, 3'd7, 8'h00);
        check("R2 pll full write", pll_q, 8'hA5);
        // R3: power-mode write with gate closed is ignored
        bus(1, 3'd1, 8'hFF);
        check("R3 pmode closed", pmode_q, 8'h00);

        random_burst(400);

        // directed: refused lock (R5), then granted lock (R4)
        do_reset();
        bus(1, 3'd2, 8'h0A);          // select bit set
        bus(1, 3'd0, 8'h01);
        bus(1, 3'd1, 8'h01);
        check("R5 refused pulse", {7'b0, lock_rej_o}, 8'h01);
        bus(0, 3'd0, 8'h00);
        check("R5 pulse one cycle", {7'b0, lock_rej_o}, 8'h00);
        bus(1, 3'd2, 8'h08);
        bus(1, 3'd1, 8'h81);
        check("R4 lock granted", {7'b0, lock_o}, 8'h01);
        bus(1, 3'd0, 8'h00);
        // R6: clear attempt with gate open
        bus(1, 3'd0, 8'h01);
        bus(1, 3'd1, 8'h40);
        check("R6 sticky", pmode_q, 8'h41);
        // R7/R10: same protected value gives no pulse
        bus(1, 3'd2, 8'hF8);
        check("R7 upper writable", clk0_q, 8'hF8);
        check("R10 no pulse on equal", {7'b0, viol_o}, 8'h00);
        bus(1, 3'd5, 8'h00);
        check("R9 pll held", pll_q, 8'h12);
        check("R10 pulse", {7'b0, viol_o}, 8'h01);

        random_burst(1500);
        do_reset();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule